// File: doc/BRIEF.md
# Strobe-Pipelined Fuse ROM Read Port

This block models the read path of a small one-time-programmable byte memory that is driven by a single chip-enable strobe. The strobe is sampled by the system clock, and its edges are found in the clock domain. When the strobe goes low, the address bus is captured and the row and column decoders are armed. When the strobe goes high again, the addressed byte moves into an output holding register. A read therefore spans one complete strobe pulse. The held byte stays on the output until the next rising strobe edge, so a host can start the next access while it still consumes the previous byte.

The array is organised as 64 rows of 64 bits. The upper six address bits choose a row and the lower three choose one of eight byte lanes within that row. Fuse contents are computed at elaboration from two parameters. An unprogrammed bit reads as 0. The output bus follows the usual FPGA pad style: a data vector plus a drive-enable, with the actual tri-state buffer placed at the pad. The drive-enable depends only on three output-enable pins of mixed polarity and never on the strobe. A program-enable pin must stay low for normal operation. While it is high, a rising strobe edge leaves the held byte unchanged.

Top module: `edge_prom_reader`

## Requirements
- R1: While reset is high and on the first cycle after it, q_out reads 0x00 and q_oe reads 0.
- R2: Word index i equals addr_in with bits [8:3] as the row and bits [2:0] as the byte lane. With the default parameters, word i holds the low 8 bits of i*13, XORed with 0xA5 when bit 8 of i is set.
- R3: The address used by a read is the value on addr_in in the first clock sample that sees strobe_in low. Changes to addr_in later in the low phase do not affect the byte returned.
- R4: q_out changes only after a rising strobe edge. It stays constant while the strobe stays high, and through the low phase of the following read, until that read's rising edge.
- R5: q_oe is 1 exactly when oe_n_a=0, oe_n_b=0 and oe_c=1 were present at the previous clock edge. Any other combination gives q_oe=0.
- R6: q_oe follows the enable pins whatever the level of strobe_in, including in the middle of a strobe-low phase.
- R7: If prog_en is high when the rising strobe edge is sampled, q_out keeps its previous value. A later read with prog_en low updates q_out normally.
- R8: A location that is never programmed reads as 0. Address 0x000 returns 0x00.
- R9: The strobe is driven between clock edges. After strobe_in rises, q_out still holds the old byte after the first clock edge and shows the new byte after the second edge.
- R10: A low phase of two clock samples is long enough for a correct read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_in | input | 1 | Chip-enable strobe; falling edge captures the address, rising edge captures the data |
| addr_in | input | 9 | Word address |
| prog_en | input | 1 | Program enable; must be low for reads |
| oe_n_a | input | 1 | Output enable, active low |
| oe_n_b | input | 1 | Output enable, active low |
| oe_c | input | 1 | Output enable, active high |
| q_out | output | 8 | Held data byte |
| q_oe | output | 1 | Pad drive enable for q_out |

## Verification
The hardest case to reach is a read whose captured address differs from what sits on the bus at the rising edge. The stimulus flips every address bit one cycle after the strobe falls. It picks the pair 0x0AA and 0x155 so that the two words differ, which makes a late capture visible. A second hard case is the pipelined hold. The bench starts a new low phase and samples q_out during it, to show the previous byte survives until the new rising edge. It also toggles the output enables inside that window, which shows that the drive-enable ignores the strobe.

// File: rtl/prom_pkg.sv
package prom_pkg;
  localparam int DEF_ADDR_W = 9;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_COL_W  = 3;

  typedef struct packed {
    logic fall;
    logic rise;
  } strobe_evt_t;
endpackage

// File: rtl/prom_strobe_sync.sv
module prom_strobe_sync
  import prom_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              prog_en,
  output strobe_evt_t       evt,
  output logic [ADDR_W-1:0] addr_smp,
  output logic              prog_smp
);
  // Stage 1 samples the pins together; stage 2 keeps the previous strobe level.
  logic stb_s1, stb_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_s1   <= 1'b1;
      stb_s2   <= 1'b1;
      addr_smp <= '0;
      prog_smp <= 1'b0;
    end else begin
      stb_s1   <= strobe_in;
      stb_s2   <= stb_s1;
      addr_smp <= addr_in;
      prog_smp <= prog_en;
    end
  end

  assign evt.fall = stb_s2 & ~stb_s1;
  assign evt.rise = ~stb_s2 & stb_s1;
endmodule

// File: rtl/prom_addr_decode.sv
module prom_addr_decode
  import prom_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int COL_W  = DEF_COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_evt_t       evt,
  input  logic [ADDR_W-1:0] addr_smp,
  output logic [ADDR_W-1:0] addr_lat,
  output logic              armed,
  output logic [(1<<(ADDR_W-COL_W))-1:0] row_hot,
  output logic [(1<<COL_W)-1:0]          col_hot,
  output logic [ADDR_W-COL_W-1:0]        row_idx
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;

  logic [COL_W-1:0] col_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lat <= '0;
      armed    <= 1'b0;
    end else if (evt.fall) begin
      addr_lat <= addr_smp;
      armed    <= 1'b1;
    end else if (evt.rise) begin
      armed    <= 1'b0;
    end
  end

  assign row_idx = addr_lat[ADDR_W-1:COL_W];
  assign col_idx = addr_lat[COL_W-1:0];

  // Gated one-hot decoders: quiet until a falling strobe edge arms them.
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign row_hot[g] = armed && (row_idx == ROW_W'(g));
  end
  for (genvar g = 0; g < COLS; g++) begin : g_col
    assign col_hot[g] = armed && (col_idx == COL_W'(g));
  end
endmodule

// File: rtl/prom_fuse_array.sv
module prom_fuse_array
  import prom_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int COL_W  = DEF_COL_W,
  parameter logic [DATA_W-1:0] FUSE_KEY = 'hA5,
  parameter int FUSE_MULT = 13
) (
  input  logic                              clk,
  input  logic [(1<<(ADDR_W-COL_W))-1:0]    row_hot,
  input  logic [ADDR_W-COL_W-1:0]           row_idx,
  input  logic [(1<<COL_W)-1:0]             col_hot,
  output logic [DATA_W-1:0]                 sel_byte
);
  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int COLS     = 1 << COL_W;
  localparam int ROW_BITS = DATA_W * COLS;

  function automatic logic [DATA_W-1:0] fuse_word(input int idx);
    int prod;
    logic [DATA_W-1:0] w;
    prod = idx * FUSE_MULT;
    w    = prod[DATA_W-1:0];
    if (((idx >> (ADDR_W-1)) & 1) != 0) w = w ^ FUSE_KEY;
    return w;
  endfunction

  logic [ROW_BITS-1:0] fuse_mem [ROWS];
  logic [ROW_BITS-1:0] row_q;
  logic                rd_en;

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        fuse_mem[r][c*DATA_W +: DATA_W] = fuse_word(r * COLS + c);
      end
    end
  end

  assign rd_en = |row_hot;

  // Registered row read, block-RAM style, no reset on the data path.
  always_ff @(posedge clk) begin
    if (rd_en) row_q <= fuse_mem[row_idx];
  end

  logic [DATA_W-1:0] lane_term [COLS];
  for (genvar g = 0; g < COLS; g++) begin : g_lane
    assign lane_term[g] = {DATA_W{col_hot[g]}} & row_q[g*DATA_W +: DATA_W];
  end

  always_comb begin
    sel_byte = '0;
    for (int c = 0; c < COLS; c++) sel_byte = sel_byte | lane_term[c];
  end
endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage
  import prom_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_evt_t       evt,
  input  logic              armed,
  input  logic              prog_smp,
  input  logic [DATA_W-1:0] sel_byte,
  input  logic              oe_n_a,
  input  logic              oe_n_b,
  input  logic              oe_c,
  output logic [DATA_W-1:0] q_out,
  output logic              q_oe
);
  logic load;
  assign load = evt.rise & armed & ~prog_smp;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out <= '0;
      q_oe  <= 1'b0;
    end else begin
      q_oe <= ~oe_n_a & ~oe_n_b & oe_c;
      if (load) q_out <= sel_byte;
    end
  end
endmodule

// File: rtl/edge_prom_reader.sv
module edge_prom_reader
  import prom_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int COL_W  = DEF_COL_W,
  parameter logic [DATA_W-1:0] FUSE_KEY = 'hA5,
  parameter int FUSE_MULT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              prog_en,
  input  logic              oe_n_a,
  input  logic              oe_n_b,
  input  logic              oe_c,
  output logic [DATA_W-1:0] q_out,
  output logic              q_oe
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;

  strobe_evt_t       evt;
  logic [ADDR_W-1:0] addr_smp;
  logic              prog_smp;
  logic [ADDR_W-1:0] addr_lat;
  logic              armed;
  logic [ROWS-1:0]   row_hot;
  logic [COLS-1:0]   col_hot;
  logic [ROW_W-1:0]  row_idx;
  logic [DATA_W-1:0] sel_byte;

  prom_strobe_sync #(.ADDR_W(ADDR_W)) u_sync (
    .clk(clk), .rst(rst), .strobe_in(strobe_in), .addr_in(addr_in),
    .prog_en(prog_en), .evt(evt), .addr_smp(addr_smp), .prog_smp(prog_smp)
  );

  prom_addr_decode #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_dec (
    .clk(clk), .rst(rst), .evt(evt), .addr_smp(addr_smp),
    .addr_lat(addr_lat), .armed(armed), .row_hot(row_hot),
    .col_hot(col_hot), .row_idx(row_idx)
  );

  prom_fuse_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W),
    .FUSE_KEY(FUSE_KEY), .FUSE_MULT(FUSE_MULT)
  ) u_arr (
    .clk(clk), .row_hot(row_hot), .row_idx(row_idx),
    .col_hot(col_hot), .sel_byte(sel_byte)
  );

  prom_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .evt(evt), .armed(armed), .prog_smp(prog_smp),
    .sel_byte(sel_byte), .oe_n_a(oe_n_a), .oe_n_b(oe_n_b), .oe_c(oe_c),
    .q_out(q_out), .q_oe(q_oe)
  );
endmodule

// File: rtl/edge_prom_reader_chk.sv
module edge_prom_reader_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_in,
  input logic              prog_en,
  input logic              oe_n_a,
  input logic              oe_n_b,
  input logic              oe_c,
  input logic [DATA_W-1:0] q_out,
  input logic              q_oe,
  input logic [ADDR_W-1:0] addr_lat
);
  // R1: cleared outputs right after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (q_out == '0) && !q_oe);

  // R5: drive enable tracks the three enable pins, one edge later
  a_r5_drive_follows_pins: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> q_oe == $past(~oe_n_a & ~oe_n_b & oe_c));

  // R4: held byte only moves after a low-then-high strobe pattern
  a_r4_hold_between_rises: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst,2) && !$past(rst,3) &&
     !($past(strobe_in,2) && !$past(strobe_in,3))) |-> $stable(q_out));

  // R3: latched address only moves after a high-then-low strobe pattern
  a_r3_addr_only_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst,2) && !$past(rst,3) &&
     !(!$past(strobe_in,2) && $past(strobe_in,3))) |-> $stable(addr_lat));

  // R7: program enable blocks the data update
  a_r7_prog_blocks_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst,2) && $past(prog_en,2)) |-> $stable(q_out));
endmodule

bind edge_prom_reader edge_prom_reader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .strobe_in(strobe_in), .prog_en(prog_en),
  .oe_n_a(oe_n_a), .oe_n_b(oe_n_b), .oe_c(oe_c),
  .q_out(q_out), .q_oe(q_oe), .addr_lat(addr_lat)
);

// File: tb/test_edge_prom_reader.sv
`timescale 1ns/1ps
module test_edge_prom_reader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_in = 1'b1;
  logic [8:0] addr_in = '0;
  logic       prog_en = 1'b0;
  logic       oe_n_a = 1'b1;
  logic       oe_n_b = 1'b1;
  logic       oe_c = 1'b0;
  logic [7:0] q_out;
  logic       q_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] prev;

  always #4 clk = ~clk;

  edge_prom_reader i_edge_prom_reader (
    .clk(clk), .rst(rst), .strobe_in(strobe_in), .addr_in(addr_in),
    .prog_en(prog_en), .oe_n_a(oe_n_a), .oe_n_b(oe_n_b), .oe_c(oe_c),
    .q_out(q_out), .q_oe(q_oe)
  );

  // {address, expected byte}, values from the R2 content rule
  localparam logic [16:0] VECS [8] = '{
    {9'h000, 8'h00}, {9'h001, 8'h0D}, {9'h1FF, 8'h56}, {9'h100, 8'hA5},
    {9'h0AA, 8'hA2}, {9'h155, 8'hF4}, {9'h038, 8'hD8}, {9'h1C7, 8'hBE}
  };

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One strobe pulse; checks old byte after one edge (R9) and new after two.
  task automatic pulse(input logic [8:0] a, input int low_n, input bit scramble,
                       input logic [7:0] exp_new, input string tag);
    addr_in   = a;
    strobe_in = 1'b0;
    @(negedge clk);
    if (scramble) addr_in = ~a;
    repeat (low_n - 1) @(negedge clk);
    strobe_in = 1'b1;
    @(negedge clk);
    chk8("R9 old byte one edge after rise", q_out, prev);
    @(negedge clk);
    chk8(tag, q_out, exp_new);
    prev = q_out;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk8("R1 q_out in reset", q_out, 8'h00);
    chk1("R1 q_oe in reset", q_oe, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk8("R1 q_out after reset", q_out, 8'h00);
    chk1("R1 q_oe after reset", q_oe, 1'b0);
    prev = 8'h00;

    // R5: only the 0,0,1 pattern drives
    oe_n_a = 0; oe_n_b = 0; oe_c = 1;
    @(negedge clk);
    chk1("R5 enabled pattern", q_oe, 1'b1);
    oe_n_a = 1;
    @(negedge clk);
    chk1("R5 oe_n_a high", q_oe, 1'b0);
    oe_n_a = 0; oe_n_b = 1;
    @(negedge clk);
    chk1("R5 oe_n_b high", q_oe, 1'b0);
    oe_n_b = 0; oe_c = 0;
    @(negedge clk);
    chk1("R5 oe_c low", q_oe, 1'b0);
    oe_c = 1;
    @(negedge clk);

    // R2 / R8 / R10 table walk, alternating 2- and 3-sample low phases
    for (int i = 0; i < 8; i++) begin
      pulse(VECS[i][16:8], (i % 2 == 0) ? 2 : 3, 1'b0, VECS[i][7:0],
            (i == 0) ? "R8 unprogrammed word" : "R2 R10 table read");
      repeat (2) @(negedge clk);
    end

    // R3: address flipped after capture must not matter
    pulse(9'h0AA, 4, 1'b1, 8'hA2, "R3 late address change ignored");
    repeat (2) @(negedge clk);

    // R4: strobe high, address wandering, byte steady
    for (int k = 0; k < 6; k++) begin
      addr_in = 9'(k * 61);
      @(negedge clk);
    end
    chk8("R4 stable while strobe high", q_out, 8'hA2);

    // R4 + R6: new low phase, old byte held; enables act mid-phase
    addr_in   = 9'h1C7;
    strobe_in = 1'b0;
    @(negedge clk);
    oe_c = 0;
    @(negedge clk);
    chk8("R4 old byte during next low phase", q_out, 8'hA2);
    chk1("R6 q_oe off with strobe low", q_oe, 1'b0);
    oe_c = 1;
    @(negedge clk);
    chk1("R6 q_oe back on with strobe low", q_oe, 1'b1);
    strobe_in = 1'b1;
    repeat (2) @(negedge clk);
    chk8("R4 new byte after rise", q_out, 8'hBE);
    prev = q_out;
    repeat (2) @(negedge clk);

    // R7: program enable suppresses the update
    prog_en = 1'b1;
    @(negedge clk);
    pulse(9'h1FF, 3, 1'b0, 8'hBE, "R7 held while prog_en high");
    prog_en = 1'b0;
    repeat (2) @(negedge clk);
    pulse(9'h1FF, 3, 1'b0, 8'h56, "R7 read resumes after prog_en low");

    // R1: reset mid-operation clears the outputs
    rst = 1'b1;
    @(negedge clk);
    chk8("R1 q_out cleared by reset", q_out, 8'h00);
    chk1("R1 q_oe cleared by reset", q_oe, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule